// File: doc/BRIEF.md
# No-Turnaround Synchronous SRAM

This block is a synchronous static RAM. Reads and writes can change places on every clock without an idle cycle between them. The address, the controls and the byte enables are sampled on the rising clock edge. Write data is sampled later than its address, so the data bus stays in step with the read data of neighbouring cycles. A static mode input picks one of two read latencies:

- Flow-through (`pipe_mode` = 0): read data appears in the cycle right after the address edge. Write data is taken one edge after its address.
- Pipeline (`pipe_mode` = 1): read data passes through an output register and appears one edge later. Write data is taken two edges after its address.

An access starts only when all three chip selects are active. A clock enable freezes the whole block. A two-bit burst sequencer lets a cycle reuse the internal address instead of a new one. The word is split into bytes of 9 bits, and each byte has its own write enable. The output enable and the sleep input act without the clock. The data bus is modelled as a separate input word, output word and drive flag.

Top module: `nbt_sram`

## Requirements
- R1: After reset `dq_oe` and `dout` are 0, and no burst is in progress: a continue cycle (`adv`=1) issued first is ignored.
- R2: In flow-through mode, a read sampled at edge k drives its word on `dout` with `dq_oe`=1 from just after edge k until edge k+1.
- R3: In pipeline mode, a read sampled at edge k drives its word from just after edge k+1. `dq_oe` is 0 after the edge that follows a write or a deselect.
- R4: Write data on `din` is sampled at edge k+1 in flow-through mode and at edge k+2 in pipeline mode, where k is the address edge. Only the 9-bit bytes whose `be` bit was 1 at edge k are written; `be[b]` covers bits 9b+8..9b.
- R5: Reads and writes may alternate on consecutive edges with no idle cycle. A read always returns the data of every write sampled before it, including a write whose data phase falls on the read's own array access edge.
- R6: Unless `sel_a`, `sel_b` and `sel_c` are all 1, a cycle that is not a continue is a deselect. It writes nothing and leaves `dq_oe`=0 at its output stage.
- R7: While `clk_en` is 0 nothing changes: the burst state does not move, no pending write commits, and `dout`/`dq_oe` hold their values.
- R8: With `burst_ilv`=0, each continue cycle adds one to the two low address bits of the burst start, modulo 4. The fourth continue returns to the start address.
- R9: With `burst_ilv`=1, the n-th continue uses the low bits start XOR (n mod 4).
- R10: A continue takes its read/write type from the access that opened the burst, whatever `wr` is, and uses the current `be`. A continue issued while deselected is ignored.
- R11: `oe`=0 forces `dq_oe` and `dout` to 0 at once, without waiting for a clock edge. Raising `oe` again restores the held read word.
- R12: While `sleep` is 1, `dq_oe` is 0 and no cycle is accepted. The stored contents survive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pipe_mode | input | 1 | 1 = pipeline latency, 0 = flow-through |
| clk_en | input | 1 | Clock enable; 0 holds every state |
| sleep | input | 1 | Asynchronous standby request |
| oe | input | 1 | Asynchronous output enable |
| sel_a | input | 1 | Chip select, active high |
| sel_b | input | 1 | Chip select, active high |
| sel_c | input | 1 | Chip select, active high |
| wr | input | 1 | 1 = write, 0 = read for a new access |
| adv | input | 1 | Burst continue |
| burst_ilv | input | 1 | 1 = interleaved burst order, 0 = linear |
| addr | input | AW | Word address |
| be | input | NB | Byte write enables |
| din | input | NB*BW | Late write data |
| dout | output | NB*BW | Read data, 0 while not driven |
| dq_oe | output | 1 | Read data is being driven |

## Verification
Two events can fall on the same array edge: the data phase of a write and the array access of a read of the same word. The bench provokes this with a write followed directly by a read of the same address. In pipeline mode it also uses a write, an unrelated read, then the read. The byte enables in these runs are partial, and the returned word is judged byte by byte against an arithmetic model that is updated in command order. A second overlap comes from a clock-enable hold placed between a write's address and its data phase. After the hold the commit must still land, and a read must see it.

// File: rtl/nbt_pkg.sv
package nbt_pkg;

  // Low address bits of a burst step: linear count or XOR with the step number
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] step_n,
                                           input logic       ilv);
    return ilv ? (start ^ step_n) : (start + step_n);
  endfunction

endpackage

// File: rtl/nbt_burst_seq.sv
module nbt_burst_seq
  import nbt_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          ce_ok,
  input  logic          adv,
  input  logic          ilv,
  input  logic          wr_in,
  input  logic [AW-1:0] addr_in,
  output logic          acc_vld,
  output logic          acc_wr,
  output logic [AW-1:0] acc_addr
);

  logic          act;
  logic          bwr;
  logic [AW-1:0] base;
  logic [1:0]    cnt;
  logic [1:0]    nxt_cnt;

  assign nxt_cnt = cnt + 2'd1;

  always_comb begin
    if (adv) begin
      acc_vld  = act;
      acc_wr   = bwr;
      acc_addr = {base[AW-1:2], burst_low(base[1:0], nxt_cnt, ilv)};
    end else begin
      acc_vld  = ce_ok;
      acc_wr   = wr_in;
      acc_addr = addr_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act  <= 1'b0;
      bwr  <= 1'b0;
      base <= '0;
      cnt  <= '0;
    end else if (step) begin
      if (adv) begin
        if (act) cnt <= nxt_cnt;
      end else if (ce_ok) begin
        act  <= 1'b1;
        bwr  <= wr_in;
        base <= addr_in;
        cnt  <= '0;
      end else begin
        act <= 1'b0;
      end
    end
  end

  // R8: each accepted continue moves the counter by exactly one (mod 4)
  p_burst_step_r8: assert property (@(posedge clk) disable iff (rst)
    (step && adv && act) |=> (cnt == $past(cnt) + 2'd1));

  // R10: a continue while idle leaves the burst idle
  p_idle_cont_r10: assert property (@(posedge clk) disable iff (rst)
    (step && adv && !act) |=> !act);

  // R7: hold keeps the burst counter
  p_hold_cnt_r7: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(cnt) && $stable(act));

endmodule

// File: rtl/nbt_ctrl.sv
module nbt_ctrl #(
  parameter int AW = 8,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          pipe_mode,
  input  logic          acc_vld,
  input  logic          acc_wr,
  input  logic [AW-1:0] acc_addr,
  input  logic [NB-1:0] be_in,
  output logic          rd_go,
  output logic [AW-1:0] rd_addr,
  output logic          wr_go,
  output logic [AW-1:0] wr_addr,
  output logic [NB-1:0] wr_be,
  output logic          rd_vld
);

  logic          s1_vld, s1_wr, s2_vld, s2_wr;
  logic [AW-1:0] s1_addr, s2_addr;
  logic [NB-1:0] s1_be, s2_be;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
      s1_wr  <= 1'b0;
      s2_vld <= 1'b0;
      s2_wr  <= 1'b0;
      rd_vld <= 1'b0;
    end else if (step) begin
      s1_vld <= acc_vld;
      s1_wr  <= acc_wr;
      s2_vld <= s1_vld;
      s2_wr  <= s1_wr;
      rd_vld <= rd_go;
    end
  end

  always_ff @(posedge clk) begin
    if (step) begin
      s1_addr <= acc_addr;
      s1_be   <= be_in;
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
    end
  end

  // Array read one stage after the command in pipeline mode; writes one stage later still
  always_comb begin
    if (pipe_mode) begin
      rd_go   = s1_vld && !s1_wr;
      rd_addr = s1_addr;
      wr_go   = s2_vld && s2_wr;
      wr_addr = s2_addr;
      wr_be   = s2_be;
    end else begin
      rd_go   = acc_vld && !acc_wr;
      rd_addr = acc_addr;
      wr_go   = s1_vld && s1_wr;
      wr_addr = s1_addr;
      wr_be   = s1_be;
    end
  end

  // R6: a cycle with no access leaves the first stage empty
  p_desel_r6: assert property (@(posedge clk) disable iff (rst)
    (step && !acc_vld) |=> !s1_vld);

  // R3: in pipeline mode a read command turns into output data one edge later
  p_pipe_read_r3: assert property (@(posedge clk) disable iff (rst)
    (step && pipe_mode && s1_vld && !s1_wr) |=> rd_vld);

  // R4: in pipeline mode a write reaches the commit stage two edges after its address
  p_late_write_r4: assert property (@(posedge clk) disable iff (rst)
    (step && pipe_mode && $past(step) && $past(acc_vld && acc_wr)) |=> (s2_vld && s2_wr));

endmodule

// File: rtl/nbt_array.sv
module nbt_array #(
  parameter int NB    = 4,
  parameter int BW    = 9,
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             wr_go,
  input  logic [AW-1:0]    wr_addr,
  input  logic [NB-1:0]    wr_be,
  input  logic [NB*BW-1:0] din,
  input  logic             rd_go,
  input  logic [AW-1:0]    rd_addr,
  output logic [NB*BW-1:0] rd_word
);

  localparam int W = NB * BW;

  logic [W-1:0]  mem [DEPTH];
  logic [W-1:0]  raw_q;
  logic [W-1:0]  fwd_dat;
  logic [NB-1:0] fwd_mask;

  always_ff @(posedge clk) begin
    if (en && wr_go) begin
      for (int b = 0; b < NB; b++) begin
        if (wr_be[b]) mem[wr_addr][b*BW +: BW] <= din[b*BW +: BW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (en && rd_go) raw_q <= mem[rd_addr];
  end

  // Bytes committed on the same edge as the read come from the write bus
  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_mask <= '0;
      fwd_dat  <= '0;
    end else if (en && rd_go) begin
      fwd_mask <= (wr_go && (wr_addr == rd_addr)) ? wr_be : '0;
      fwd_dat  <= din;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_merge
    assign rd_word[b*BW +: BW] = fwd_mask[b] ? fwd_dat[b*BW +: BW] : raw_q[b*BW +: BW];
  end

  // R7: a held cycle leaves the read word untouched
  p_hold_word_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(fwd_mask) && $stable(fwd_dat));

  // R5: forwarding only happens when a write and a read met at one edge
  p_fwd_src_r5: assert property (@(posedge clk) disable iff (rst)
    (en && rd_go && !wr_go) |=> (fwd_mask == '0));

endmodule

// File: rtl/nbt_sram.sv
module nbt_sram #(
  parameter int NB    = 4,
  parameter int BW    = 9,
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pipe_mode,
  input  logic             clk_en,
  input  logic             sleep,
  input  logic             oe,
  input  logic             sel_a,
  input  logic             sel_b,
  input  logic             sel_c,
  input  logic             wr,
  input  logic             adv,
  input  logic             burst_ilv,
  input  logic [AW-1:0]    addr,
  input  logic [NB-1:0]    be,
  input  logic [NB*BW-1:0] din,
  output logic [NB*BW-1:0] dout,
  output logic             dq_oe
);

  localparam int W = NB * BW;

  logic          step;
  logic          ce_ok;
  logic          acc_vld, acc_wr;
  logic [AW-1:0] acc_addr;
  logic          rd_go, wr_go, rd_vld;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [NB-1:0] wr_be;
  logic [W-1:0]  rd_word;

  assign step  = clk_en && !sleep;
  assign ce_ok = sel_a && sel_b && sel_c;

  nbt_burst_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst(rst), .step(step), .ce_ok(ce_ok), .adv(adv),
    .ilv(burst_ilv), .wr_in(wr), .addr_in(addr),
    .acc_vld(acc_vld), .acc_wr(acc_wr), .acc_addr(acc_addr)
  );

  nbt_ctrl #(.AW(AW), .NB(NB)) u_ctrl (
    .clk(clk), .rst(rst), .step(step), .pipe_mode(pipe_mode),
    .acc_vld(acc_vld), .acc_wr(acc_wr), .acc_addr(acc_addr), .be_in(be),
    .rd_go(rd_go), .rd_addr(rd_addr), .wr_go(wr_go), .wr_addr(wr_addr),
    .wr_be(wr_be), .rd_vld(rd_vld)
  );

  nbt_array #(.NB(NB), .BW(BW), .DEPTH(DEPTH), .AW(AW)) u_arr (
    .clk(clk), .rst(rst), .en(step), .wr_go(wr_go), .wr_addr(wr_addr),
    .wr_be(wr_be), .din(din), .rd_go(rd_go), .rd_addr(rd_addr),
    .rd_word(rd_word)
  );

  assign dq_oe = oe && !sleep && rd_vld;
  assign dout  = dq_oe ? rd_word : '0;

  // R12: standby never drives the bus
  p_sleep_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    sleep |-> !dq_oe);

  // R1: reset leaves the output stage idle
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> !dq_oe);

  // R7: a hold keeps the output drive state
  p_hold_drive_r7: assert property (@(posedge clk) disable iff (rst)
    (!clk_en && !sleep && $past(!sleep) && oe && $past(oe)) |=> $stable(dq_oe));

endmodule

// File: tb/sim_nbt_sram.sv
`timescale 1ns/100ps
module sim_nbt_sram;
  localparam int NB = 4, BW = 9, W = 36, DEPTH = 256, AW = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, pipe_mode, clk_en, sleep, oe, sel_a, sel_b, sel_c, wr, adv, burst_ilv;
  logic [AW-1:0] addr;
  logic [NB-1:0] be;
  logic [W-1:0]  din, dout;
  logic          dq_oe;

  nbt_sram #(.NB(NB), .BW(BW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .clk_en(clk_en), .sleep(sleep),
    .oe(oe), .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .wr(wr), .adv(adv),
    .burst_ilv(burst_ilv), .addr(addr), .be(be), .din(din), .dout(dout), .dq_oe(dq_oe)
  );

  int errors = 0, checks = 0, cyc = 0, lat = 0;
  logic [W-1:0] model [DEPTH];
  logic [W-1:0] sd_din [8];
  bit           sx_chk [8];
  bit           sx_on  [8];
  logic [W-1:0] sx_val [8];
  string        sx_tag [8];
  bit b_act = 0, b_wr = 0;
  logic [AW-1:0] b_base = '0;
  logic [1:0]    b_cnt = '0;

  function automatic logic [W-1:0] pat(input int a, input int s);
    return W'(a) * 36'h0_0A5_3C1 + W'(s) * 36'h7_1234_567 + 36'h9_5A3_0F1;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    int s;
    din = sd_din[cyc % 8];
    @(posedge clk);
    @(negedge clk);
    s = cyc % 8;
    if (sx_chk[s]) begin
      chk(sx_tag[s], W'(dq_oe), W'(sx_on[s]));
      chk(sx_tag[s], dout, sx_on[s] ? sx_val[s] : '0);
      sx_chk[s] = 0;
    end
    cyc++;
  endtask

  task automatic issue(input logic [2:0] ces, input bit w, input bit a,
                       input logic [AW-1:0] ap, input logic [NB-1:0] bev,
                       input logic [W-1:0] dv, input string tag);
    bit eff, ew;
    logic [AW-1:0] ea;
    int rs;
    {sel_a, sel_b, sel_c} = ces;
    wr = w; adv = a; addr = ap; be = bev;
    eff = 0; ew = 0; ea = ap;
    if (a) begin
      eff = b_act; ew = b_wr;
      if (b_act) begin
        b_cnt = b_cnt + 2'd1;
        ea = {b_base[AW-1:2], burst_ilv ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt)};
      end
    end else if (ces == 3'b111) begin
      eff = 1; ew = w; ea = ap;
      b_act = 1; b_wr = w; b_base = ap; b_cnt = 0;
    end else begin
      b_act = 0;
    end
    if (eff && ew) begin
      for (int b = 0; b < NB; b++)
        if (bev[b]) model[ea][b*BW +: BW] = dv[b*BW +: BW];
      sd_din[(cyc + lat + 1) % 8] = dv;
    end
    rs = (cyc + lat) % 8;
    sx_chk[rs] = 1;
    sx_on[rs]  = eff && !ew;
    sx_val[rs] = model[ea];
    sx_tag[rs] = tag;
    tick();
  endtask

  task automatic hold(input string tag);
    logic [W-1:0] d0;
    logic o0;
    d0 = dout; o0 = dq_oe;
    clk_en = 0; addr = addr + 8'd37; wr = ~wr; adv = ~adv;
    @(posedge clk);
    @(negedge clk);
    chk(tag, W'(dq_oe), W'(o0));
    chk(tag, dout, d0);
    clk_en = 1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) issue(3'b000, 0, 0, '0, '0, '0, "R6");
  endtask

  task automatic do_reset(input bit pm);
    rst = 1; pipe_mode = pm; lat = pm ? 1 : 0;
    for (int i = 0; i < 8; i++) sx_chk[i] = 0;
    b_act = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clk_en = 1; sleep = 0; oe = 1; burst_ilv = 0;
    {sel_a, sel_b, sel_c} = 3'b000; wr = 0; adv = 0; addr = '0; be = '0; din = '0;
    for (int i = 0; i < 8; i++) sd_din[i] = '0;
    do_reset(0);
    chk("R1", W'(dq_oe), '0);
    chk("R1", dout, '0);
    issue(3'b111, 0, 1, 8'd3, '0, '0, "R1");

    // Flow-through: fill and read back every word
    for (int a = 0; a < DEPTH; a++) issue(3'b111, 1, 0, AW'(a), 4'hF, pat(a, 0), "R4");
    for (int a = 0; a < DEPTH; a++) issue(3'b111, 0, 0, AW'(a), '0, '0, "R2");

    // R5: write then read of the same word on consecutive edges
    for (int a = 0; a < 32; a++) begin
      issue(3'b111, 1, 0, AW'(a), AW'(a) % 2 ? 4'hA : 4'h7, pat(a, 1), "R5");
      issue(3'b111, 0, 0, AW'(a), '0, '0, "R5");
    end
    // R4: every byte-enable combination
    for (int m = 0; m < 16; m++) begin
      issue(3'b111, 1, 0, AW'(100 + m), NB'(m), pat(m, 2), "R4");
      issue(3'b111, 0, 0, AW'(100 + m), '0, '0, "R4");
    end
    // R6: every partial chip-select combination
    for (int k = 0; k < 7; k++) begin
      issue(3'(k), 1, 0, 8'd200, 4'hF, pat(k, 3), "R6");
      issue(3'(k), 0, 0, 8'd200, '0, '0, "R6");
    end
    issue(3'b111, 0, 0, 8'd200, '0, '0, "R6");

    // R7: holds during a read and between a write and its data phase
    issue(3'b111, 0, 0, 8'd10, '0, '0, "R7");
    repeat (3) hold("R7");
    issue(3'b111, 1, 0, 8'd12, 4'hF, pat(12, 4), "R7");
    repeat (2) hold("R7");
    issue(3'b111, 0, 0, 8'd12, '0, '0, "R7");

    // R8: linear read burst from low bits 2, fifth address back at start
    issue(3'b111, 0, 0, 8'd6, '0, '0, "R8");
    repeat (4) issue(3'b111, 1, 1, 8'hEE, '0, '0, "R8");
    // R10: write burst, wr pin ignored on continues
    issue(3'b111, 1, 0, 8'd21, 4'hF, pat(21, 5), "R10");
    for (int i = 0; i < 3; i++) issue(3'b111, 0, 1, 8'h00, 4'hF, pat(i, 6), "R10");
    for (int a = 20; a < 24; a++) issue(3'b111, 0, 0, AW'(a), '0, '0, "R10");
    // R9: interleaved
    burst_ilv = 1;
    issue(3'b111, 0, 0, 8'd45, '0, '0, "R9");
    repeat (4) issue(3'b111, 1, 1, 8'h11, '0, '0, "R9");
    issue(3'b111, 1, 0, 8'd51, 4'h5, pat(51, 7), "R9");
    for (int i = 0; i < 3; i++) issue(3'b111, 1, 1, 8'h00, 4'hF, pat(i, 8), "R9");
    for (int a = 48; a < 52; a++) issue(3'b111, 0, 0, AW'(a), '0, '0, "R9");
    burst_ilv = 0;
    // R10: continue after deselect is ignored, even with write on the pins
    issue(3'b000, 0, 0, 8'd0, '0, '0, "R10");
    issue(3'b111, 1, 1, 8'd60, 4'hF, pat(60, 9), "R10");
    issue(3'b111, 1, 1, 8'd60, 4'hF, pat(60, 9), "R10");
    idle(1);

    // R11: output enable acts between edges
    issue(3'b111, 0, 0, 8'd30, '0, '0, "R11");
    oe = 0; #0.5;
    chk("R11", W'(dq_oe), '0);
    chk("R11", dout, '0);
    oe = 1; #0.5;
    chk("R11", W'(dq_oe), 1);
    chk("R11", dout, model[30]);

    // R12: sleep blocks a write and keeps contents
    issue(3'b111, 0, 0, 8'd31, '0, '0, "R12");
    sleep = 1; #0.5;
    chk("R12", W'(dq_oe), '0);
    {sel_a, sel_b, sel_c} = 3'b111; wr = 1; adv = 0; addr = 8'd31; be = 4'hF; din = '1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R12", W'(dq_oe), '0);
    end
    sleep = 0;
    issue(3'b111, 0, 0, 8'd31, '0, '0, "R12");
    idle(3);

    // Pipeline mode: read every word, then the same-edge cases
    do_reset(1);
    chk("R1", W'(dq_oe), '0);
    for (int a = 0; a < DEPTH; a++) issue(3'b111, 0, 0, AW'(a), '0, '0, "R3");
    for (int a = 0; a < 16; a++) begin
      issue(3'b111, 1, 0, AW'(a), 4'hC, pat(a, 10), "R5");
      issue(3'b111, 0, 0, AW'(a), '0, '0, "R5");
      issue(3'b111, 1, 0, AW'(a + 64), 4'h3, pat(a, 11), "R5");
      issue(3'b111, 0, 0, AW'(a + 128), '0, '0, "R5");
      issue(3'b111, 0, 0, AW'(a + 64), '0, '0, "R5");
    end
    issue(3'b111, 1, 0, 8'd70, 4'h9, pat(70, 12), "R4");
    hold("R7");
    issue(3'b111, 0, 0, 8'd70, '0, '0, "R7");
    issue(3'b111, 0, 0, 8'd70, '0, '0, "R4");
    issue(3'b111, 0, 0, 8'd83, '0, '0, "R8");
    repeat (4) issue(3'b111, 1, 1, 8'h00, '0, '0, "R8");
    issue(3'b011, 1, 0, 8'd84, 4'hF, pat(84, 13), "R6");
    issue(3'b111, 0, 0, 8'd84, '0, '0, "R6");
    idle(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule